// File: doc/BRIEF.md
# Abortable Validate Delay Queue

This block sits between the logic that detects a cache line reverting to an earlier value and the port that asks for the coherence bus. Each reversion event brings in a line address for a validate broadcast. The queue holds that validate for a fixed number of cycles before offering it to the bus. If a local store that changes the value of the same line arrives during that wait, the broadcast would be useless, so the entry is cancelled. Broadcasts to lines that are rewritten quickly are filtered out. The cost is that a line which really did revert is announced to remote caches later.

The producer side is fire-and-forget and has no ready. Validates are only an optimisation, so a request that finds the queue full is dropped and the producer is never stalled. The store-notification input is a plain strobe.

The bus side is a valid/ready stream. Once `bus_valid` is high, it and `bus_addr` hold until `bus_ready` completes the transfer, with two exceptions:
- a store to the offered line withdraws the offer;
- a new validate for the offered line restarts its wait.

Entries leave the queue oldest-first. Age is counted from when the entry was accepted or last refreshed.

Top module: `validate_delay_queue`

## Requirements
- R1: Reset empties the queue. `bus_valid` is low during reset and stays low afterwards until a validate accepted after reset has waited its delay.
- R2: A validate accepted at a clock edge into a queue with no other pending entry raises `bus_valid`, with its address on `bus_addr`, exactly DELAY cycles later and never earlier.
- R3: While an offer waits with `bus_ready` low, `bus_valid` and `bus_addr` stay unchanged. The only exceptions are a store or an enqueue to that same line.
- R4: A transfer (`bus_valid` and `bus_ready` high at an edge) removes the entry, so each validate goes out once.
- R5: Ripe entries are offered in the order they were accepted or last refreshed. This holds whatever slot they occupy.
- R6: A store notification whose address equals a queued line removes that entry, and it is never sent. Entries for other lines are unaffected.
- R7: A store to the line currently offered lowers `bus_valid` in that same cycle, so no transfer of that line can happen.
- R8: Enqueuing a line that is already queued creates no duplicate. The existing entry restarts its delay and moves behind every other pending entry.
- R9: With DEPTH entries pending, an enqueue for a new line is silently dropped. Occupancy grows by at most one per cycle.
- R10: When a store and an enqueue for the same queued line fall in one cycle, the enqueue wins. The entry survives with a fresh delay.
- R11: When a transfer and an enqueue for the same line fall in one cycle, the transfer completes. A new entry for that line then starts a full delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Reversion event: request a validate for `enq_addr` |
| enq_addr | input | ADDR_W | Line address of the validate to queue |
| store_valid | input | 1 | A local value-changing store happened this cycle |
| store_addr | input | ADDR_W | Line address written by that store |
| bus_valid | output | 1 | A ripe validate is offered to the bus |
| bus_ready | input | 1 | Bus takes the offered validate at this edge |
| bus_addr | output | ADDR_W | Line address of the offered validate |

## Verification
Three same-cycle collisions carry most of the risk:
- **Store against offer.** A store meets the offer of its own line. The bench holds the offer with `bus_ready` low, then raises the store and `bus_ready` together. It expects `bus_valid` low in that cycle and no transfer at all.
- **Enqueue against transfer.** An enqueue hits a line in the very cycle its validate is taken. The bench expects one logged transfer, then the same line offered again after a full delay.
- **Store against enqueue.** A store and an enqueue for one line coincide. The bench expects a single survivor with a restarted delay.

A sweep moves the store across every age from zero to past ripeness. Transfers are logged at the falling edge, and only the ages past DELAY may produce one.

// File: rtl/vdq_pkg.sv
package vdq_pkg;

  // Per-slot next-state command issued by the queue controller.
  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_LOAD  = 2'd1,
    SLOT_CLEAR = 2'd2
  } slot_cmd_e;

endpackage

// File: rtl/vdq_slot.sv
module vdq_slot
  import vdq_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DELAY  = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_cmd_e         cmd,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              live,
  output logic              ripe,
  output logic [ADDR_W-1:0] line
);

  localparam int AGE_W = $clog2(DELAY + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(DELAY);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= 1'b0;
      line  <= '0;
      age_q <= '0;
    end else begin
      unique case (cmd)
        SLOT_LOAD: begin
          live  <= 1'b1;
          line  <= load_addr;
          age_q <= '0;
        end
        SLOT_CLEAR: begin
          live  <= 1'b0;
          age_q <= '0;
        end
        default: begin
          if (live && age_q != AGE_MAX) age_q <= age_q + AGE_W'(1);
        end
      endcase
    end
  end

  assign ripe = live && (age_q == AGE_MAX);

endmodule

// File: rtl/vdq_order.sv
module vdq_order #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] touch,
  input  logic [DEPTH-1:0] live,
  input  logic [DEPTH-1:0] cand,
  output logic [DEPTH-1:0] pick
);

  // ahead_q[i][j] set: slot j was loaded before slot i.
  logic [DEPTH-1:0] ahead_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    localparam logic [DEPTH-1:0] SELF = DEPTH'(1) << i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ahead_q[i] <= '0;
      end else if (touch[i]) begin
        ahead_q[i] <= live & ~SELF;
      end else if (|touch) begin
        ahead_q[i] <= ahead_q[i] & ~touch;
      end
    end

    assign pick[i] = cand[i] && ((ahead_q[i] & cand) == '0);
  end

endmodule

// File: rtl/validate_delay_queue.sv
module validate_delay_queue
  import vdq_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DEPTH  = 8,
  parameter int DELAY  = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic              store_valid,
  input  logic [ADDR_W-1:0] store_addr,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr
);

  logic [DEPTH-1:0]  slot_valid;
  logic [DEPTH-1:0]  slot_ripe;
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  slot_cmd_e         slot_cmd  [DEPTH];

  logic [DEPTH-1:0] store_hit;
  logic [DEPTH-1:0] enq_hit;
  logic [DEPTH-1:0] alloc;
  logic [DEPTH-1:0] cand;
  logic [DEPTH-1:0] pick;
  logic [DEPTH-1:0] fire;
  logic [DEPTH-1:0] touch;

  // Parallel address compare against every slot.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign store_hit[i] = store_valid && slot_valid[i] && (slot_addr[i] == store_addr);
    assign enq_hit[i]   = enq_valid   && slot_valid[i] && (slot_addr[i] == enq_addr);
  end

  // Lowest free slot, used only when the line is not already queued.
  function automatic logic [DEPTH-1:0] first_free(input logic [DEPTH-1:0] used);
    logic [DEPTH-1:0] sel;
    logic             found;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && !used[i]) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    return sel;
  endfunction

  always_comb begin
    if (enq_valid && !(|enq_hit)) alloc = first_free(slot_valid);
    else                          alloc = '0;
  end

  // A ripe slot hit by a store this cycle is withheld from the bus.
  assign cand  = slot_ripe & ~store_hit;
  assign fire  = pick & {DEPTH{bus_ready}};
  assign touch = enq_hit | alloc;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (enq_hit[i])                  slot_cmd[i] = SLOT_LOAD;
      else if (fire[i] || store_hit[i]) slot_cmd[i] = SLOT_CLEAR;
      else if (alloc[i])               slot_cmd[i] = SLOT_LOAD;
      else                             slot_cmd[i] = SLOT_HOLD;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    vdq_slot #(
      .ADDR_W (ADDR_W),
      .DELAY  (DELAY)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (slot_cmd[i]),
      .load_addr (enq_addr),
      .live      (slot_valid[i]),
      .ripe      (slot_ripe[i]),
      .line      (slot_addr[i])
    );
  end

  vdq_order #(
    .DEPTH (DEPTH)
  ) u_order (
    .clk   (clk),
    .rst_n (rst_n),
    .touch (touch),
    .live  (slot_valid),
    .cand  (cand),
    .pick  (pick)
  );

  assign bus_valid = |pick;

  always_comb begin
    bus_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick[i]) bus_addr = bus_addr | slot_addr[i];
    end
  end

endmodule

// File: rtl/vdq_checker.sv
module vdq_checker #(
  parameter int ADDR_W = 26,
  parameter int DEPTH  = 8,
  parameter int DELAY  = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_valid,
  input logic [ADDR_W-1:0] enq_addr,
  input logic              store_valid,
  input logic [ADDR_W-1:0] store_addr,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DEPTH-1:0]  slot_valid,
  input logic [DEPTH-1:0]  pick
);

  localparam int CNT_W = $clog2(DELAY + 2);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DELAY + 1);

  logic [CNT_W-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != CNT_TOP) since_rst <= since_rst + CNT_W'(1);
  end

  always_comb begin
    if (!rst_n) p_quiet_in_reset_r1: assert (!bus_valid);
  end

  p_min_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != CNT_TOP) |-> !bus_valid);

  p_offer_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready && !(enq_valid && enq_addr == bus_addr))
    |=> (bus_valid && bus_addr == $past(bus_addr))
        || (store_valid && store_addr == $past(bus_addr)));

  p_single_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  p_store_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_valid && bus_valid) |-> (bus_addr != store_addr));

  p_one_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_valid) <= $countones($past(slot_valid)) + 1);

endmodule

bind validate_delay_queue vdq_checker #(
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH),
  .DELAY  (DELAY)
) u_vdq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .enq_valid   (enq_valid),
  .enq_addr    (enq_addr),
  .store_valid (store_valid),
  .store_addr  (store_addr),
  .bus_valid   (bus_valid),
  .bus_ready   (bus_ready),
  .bus_addr    (bus_addr),
  .slot_valid  (slot_valid),
  .pick        (pick)
);

// File: tb/validate_delay_queue_test.sv
module validate_delay_queue_test;

  localparam int PERIOD = 10;
  localparam int AW     = 8;
  localparam int NQ     = 4;
  localparam int DLY    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq_valid = 1'b0;
  logic [AW-1:0] enq_addr = '0;
  logic          store_valid = 1'b0;
  logic [AW-1:0] store_addr = '0;
  logic          bus_ready = 1'b0;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nlog = 0;
  logic [AW-1:0] log_a [32];
  int            log_c [32];

  always #(PERIOD/2) clk = ~clk;

  validate_delay_queue #(
    .ADDR_W (AW),
    .DEPTH  (NQ),
    .DELAY  (DLY)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_valid   (enq_valid),
    .enq_addr    (enq_addr),
    .store_valid (store_valid),
    .store_addr  (store_addr),
    .bus_valid   (bus_valid),
    .bus_ready   (bus_ready),
    .bus_addr    (bus_addr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Transfers are logged away from the edge that completes them.
  always @(negedge clk) begin
    if (rst_n && bus_valid && bus_ready) begin
      if (nlog < 32) begin
        log_a[nlog] = bus_addr;
        log_c[nlog] = cyc;
      end
      nlog = nlog + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic enq(input logic [AW-1:0] a);
    enq_valid = 1'b1;
    enq_addr  = a;
    step();
    enq_valid = 1'b0;
  endtask

  task automatic store(input logic [AW-1:0] a);
    store_valid = 1'b1;
    store_addr  = a;
    step();
    store_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    #1;
    chk("R1 bus_valid in reset", bus_valid, 0);
    rst_n = 1'b1;
    step();
    chk("R1 bus_valid after reset", bus_valid, 0);

    // R2 / R3 / R4: exact delay, held offer, single transfer
    nlog = 0;
    bus_ready = 1'b0;
    enq(8'h11);
    for (int k = 1; k < DLY; k++) begin
      step();
      chk("R2 no early offer", bus_valid, 0);
    end
    step();
    chk("R2 offer at delay", bus_valid, 1);
    chk("R2 offer address", bus_addr, 8'h11);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R3 offer held valid", bus_valid, 1);
      chk("R3 offer held address", bus_addr, 8'h11);
    end
    bus_ready = 1'b1;
    step();
    bus_ready = 1'b0;
    chk("R4 removed after transfer", bus_valid, 0);
    chk("R4 one transfer", nlog, 1);
    chk("R4 transfer address", log_a[0], 8'h11);

    // R5 / R6: reused low slot is younger; abort leaves neighbour intact
    nlog = 0;
    enq(8'h31);
    enq(8'h32);
    store(8'h31);
    enq(8'h33);
    idle(DLY + 2);
    bus_ready = 1'b1;
    idle(4);
    bus_ready = 1'b0;
    chk("R6 aborted entry not sent", nlog, 2);
    chk("R5 oldest first", log_a[0], 8'h32);
    chk("R5 younger second", log_a[1], 8'h33);

    // R8: refresh moves entry behind and restarts delay
    nlog = 0;
    bus_ready = 1'b1;
    enq(8'h41);
    enq(8'h42);
    idle(1);
    enq(8'h41);
    idle(DLY + 4);
    chk("R8 no duplicate", nlog, 2);
    chk("R8 refreshed goes last a", log_a[0], 8'h42);
    chk("R8 refreshed goes last b", log_a[1], 8'h41);
    chk("R8 delay restarted", log_c[1] - log_c[0], 2);
    bus_ready = 1'b0;

    // R7: store in the offer cycle suppresses it
    nlog = 0;
    enq(8'h51);
    idle(DLY);
    chk("R7 offer present", bus_valid, 1);
    store_valid = 1'b1;
    store_addr  = 8'h51;
    bus_ready   = 1'b1;
    #1;
    chk("R7 offer withdrawn", bus_valid, 0);
    step();
    store_valid = 1'b0;
    idle(DLY + 2);
    chk("R7 never sent", nlog, 0);
    bus_ready = 1'b0;

    // R9: full queue drops a new line
    nlog = 0;
    for (int k = 0; k < NQ + 1; k++) enq(AW'(8'h61 + k));
    idle(DLY + 1);
    bus_ready = 1'b1;
    idle(NQ + 3);
    bus_ready = 1'b0;
    chk("R9 only DEPTH sent", nlog, NQ);
    for (int k = 0; k < NQ; k++) chk("R9 kept entries in order", log_a[k], 8'h61 + k);

    // R10: store and enqueue of one line together
    nlog = 0;
    bus_ready = 1'b1;
    enq(8'h71);
    idle(2);
    enq_valid = 1'b1;
    enq_addr = 8'h71;
    store_valid = 1'b1;
    store_addr = 8'h71;
    step();
    enq_valid = 1'b0;
    store_valid = 1'b0;
    for (int k = 1; k < DLY; k++) begin
      step();
      chk("R10 fresh delay", bus_valid, 0);
    end
    step();
    chk("R10 entry survived", bus_valid, 1);
    chk("R10 address", bus_addr, 8'h71);
    step();
    chk("R10 one transfer", nlog, 1);
    bus_ready = 1'b0;

    // R11: transfer and enqueue of one line together
    nlog = 0;
    enq(8'h81);
    idle(DLY);
    chk("R11 offer present", bus_valid, 1);
    bus_ready = 1'b1;
    enq_valid = 1'b1;
    enq_addr = 8'h81;
    step();
    enq_valid = 1'b0;
    bus_ready = 1'b0;
    chk("R11 transfer done", nlog, 1);
    chk("R11 new entry not ripe", bus_valid, 0);
    for (int k = 1; k < DLY; k++) begin
      step();
      chk("R11 new entry waits", bus_valid, 0);
    end
    step();
    chk("R11 new entry offered", bus_valid, 1);
    chk("R11 new entry address", bus_addr, 8'h81);
    bus_ready = 1'b1;
    step();
    bus_ready = 1'b0;
    chk("R11 second transfer", nlog, 2);

    // R6 sweep: store at every age; sent only if store comes after ripeness
    bus_ready = 1'b1;
    for (int d = 0; d <= DLY + 2; d++) begin
      nlog = 0;
      enq(AW'(8'h90 + d));
      idle(d);
      store(AW'(8'h90 + d));
      idle(DLY + 2);
      chk("R6 abort window", nlog, (d > DLY) ? 1 : 0);
    end

    // R1: reset discards pending work
    nlog = 0;
    enq(8'hA1);
    rst_n = 1'b0;
    step();
    chk("R1 quiet in reset", bus_valid, 0);
    rst_n = 1'b1;
    idle(DLY + 3);
    chk("R1 pending entry discarded", nlog, 0);
    bus_ready = 1'b0;

    finish_run();
  end

endmodule